// File: doc/BRIEF.md
# Three-Level Power Mode Controller

This block sequences a small system-on-chip between a running state and three low-power levels: light sleep, deep sleep and hibernate. Each level stops a different amount of the chip. Light sleep stops only the processor clock. Deep sleep also stops the peripheral clocks, and the SRAM banks that were not chosen for retention lose power. Hibernate removes main power, and only a free-running slow counter and a pad-hold latch survive it.

Software asks for a level with a one-cycle request. In that same cycle it supplies the wake configuration for that level: a timer compare value, a bank mask, the enabled interrupt lines, and the deep-sleep and hibernate wake sources. The controller captures that configuration when it accepts the request. It then waits in the low-power level until an allowed source fires. It records the cause of the wake, runs a wake latency whose length depends on the level, and returns to the running state with a one-cycle ready pulse.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After a synchronous reset the controller is running. In that state `cpu_clk_en`, `periph_clk_en` and `main_pwr_en` are 1, every `bank_ret_en` bit is 1, and `pad_hold`, `wake_cause`, `wake_ready` and `slow_cnt` are 0.
- R2: A request with `req_mode`=1 (light sleep), accepted while running, clears `cpu_clk_en` on the next cycle. `periph_clk_en`, `main_pwr_en` and all `bank_ret_en` bits stay at 1.
- R3: Light sleep ends only when some `irq` bit that was set in `sleep_irq_en` at request time is 1. Interrupt lines that were not enabled have no effect.
- R4: A request with `req_mode`=2 (deep sleep) clears both clock enables and keeps `main_pwr_en` at 1. `bank_ret_en` then equals the `bank_keep` mask captured with the request, one bit per whole bank.
- R5: Deep sleep wakes only on three sources, using the `deep_src_en` value captured with the request. Bit 0 enables `np_irq`. Bit 1 enables a match of `slow_cnt` with the captured `timer_cmp`. Bit 2 enables the GPIO pin selected by `deep_gpio_sel`, and only when that pin is in the permitted set (the lower half of the pins by default). When several fire together the priority is network, then timer, then GPIO. Ordinary `irq` lines are ignored.
- R6: A request with `req_mode`=3 (hibernate) drives both clock enables, `main_pwr_en` and every `bank_ret_en` bit to 0. Hibernate wakes on a timer match when `hib_timer_en` was set, or on any `gpio_wake` pin enabled in `hib_gpio_en`. Timer has priority.
- R7: `slow_cnt` advances by one every `SLOW_DIV` clock cycles in every state and wraps at its width.
- R8: On entry to hibernate, the `pad_grp_keep` groups are set in `pad_hold`. When the controller wakes from hibernate, group 1 is cleared automatically. Any other group stays held until a `pad_release` bit for it is seen outside hibernate. Releases issued during hibernate are ignored.
- R9: `wake_cause` is loaded when a wake is detected: 1 means an enabled interrupt, 2 the network interrupt, 3 a timer match and 4 a GPIO pin. It returns to 0 in the cycle after `cause_rd` is sampled high.
- R10: After a wake, the controller holds `cpu_clk_en` at 0 for `LAT_SLEEP`, `LAT_DEEP` or `LAT_HIB` cycles, according to the level it left. During that time the peripheral clocks, main power and all banks are on. It then sets `cpu_clk_en` and pulses `wake_ready` for one cycle.
- R11: A request that arrives while the controller is not running, or a request with `req_mode`=0, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle mode request strobe |
| req_mode | input | 2 | Requested level: 0 run, 1 light sleep, 2 deep sleep, 3 hibernate |
| timer_cmp | input | CNT_W | Slow-counter value that wakes on match |
| bank_keep | input | NUM_BANKS | Banks kept powered in deep sleep |
| sleep_irq_en | input | NUM_IRQ | Interrupt lines allowed to end light sleep |
| deep_src_en | input | 3 | Deep-sleep sources: bit0 network, bit1 timer, bit2 GPIO |
| deep_gpio_sel | input | SEL_W | GPIO pin index used in deep sleep |
| hib_timer_en | input | 1 | Timer match ends hibernate |
| hib_gpio_en | input | NUM_GPIO | GPIO pins that end hibernate |
| pad_grp_keep | input | NUM_GROUPS | I/O groups latched on hibernate entry |
| pad_release | input | NUM_GROUPS | Per-group release of the pad latch |
| irq | input | NUM_IRQ | Interrupt lines |
| np_irq | input | 1 | Network-processor interrupt |
| gpio_wake | input | NUM_GPIO | GPIO wake pins |
| cause_rd | input | 1 | Read strobe that clears the wake cause |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| main_pwr_en | output | 1 | Main power domain enable |
| bank_ret_en | output | NUM_BANKS | SRAM bank power/retention enables |
| pad_hold | output | NUM_GROUPS | Pad hold per I/O group |
| wake_cause | output | 3 | Source of the last wake |
| wake_ready | output | 1 | One-cycle pulse when the wake latency ends |
| slow_cnt | output | CNT_W | Free-running slow counter |

## Verification
The bench builds the controller with an 8-bit slow counter and a divide of 3. With these values a timer match is reached within a dozen cycles, and a counter wrap within about 770 cycles. The wake latencies are set to 2, 5 and 9 cycles, so each level shows a different length and the model has to track each one. Eight GPIO pins with only the lower four permitted in deep sleep make it possible to pick a pin outside the permitted set and show that it has no effect.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_ACTIVE = 3'd0,
    PS_SLEEP  = 3'd1,
    PS_DEEP   = 3'd2,
    PS_HIB    = 3'd3,
    PS_WAKE   = 3'd4
  } pstate_t;

  localparam logic [1:0] REQ_ACTIVE = 2'd0;
  localparam logic [1:0] REQ_HIB    = 2'd3;

  localparam logic [2:0] WC_NONE  = 3'd0;
  localparam logic [2:0] WC_IRQ   = 3'd1;
  localparam logic [2:0] WC_NP    = 3'd2;
  localparam logic [2:0] WC_TIMER = 3'd3;
  localparam logic [2:0] WC_GPIO  = 3'd4;
endpackage

// File: rtl/pwr_slow_timer.sv
`timescale 1ns/1ps
module pwr_slow_timer #(
  parameter int CNT_W    = 16,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  localparam int PRE_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOW_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      count <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
      count <= count + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_wake_sel.sv
`timescale 1ns/1ps
module pwr_wake_sel import pwr_pkg::*; #(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_GPIO = 8,
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 3,
  parameter logic [NUM_GPIO-1:0] DEEP_GPIO_OK = '1
) (
  input  pstate_t             state,
  input  logic [NUM_IRQ-1:0]  sleep_en,
  input  logic [2:0]          deep_en,
  input  logic [SEL_W-1:0]    deep_sel,
  input  logic                hib_tmr,
  input  logic [NUM_GPIO-1:0] hib_gpio,
  input  logic [CNT_W-1:0]    cmp,
  input  logic [CNT_W-1:0]    slow,
  input  logic [NUM_IRQ-1:0]  irq,
  input  logic                np_irq,
  input  logic [NUM_GPIO-1:0] gpio,
  output logic                hit,
  output logic [2:0]          code
);
  logic match;
  logic deep_pin;

  assign match    = (slow == cmp);
  assign deep_pin = DEEP_GPIO_OK[deep_sel] & gpio[deep_sel];

  always_comb begin
    code = WC_NONE;
    unique case (state)
      PS_SLEEP: if (|(irq & sleep_en)) code = WC_IRQ;
      PS_DEEP: begin
        if (deep_en[0] && np_irq)        code = WC_NP;
        else if (deep_en[1] && match)    code = WC_TIMER;
        else if (deep_en[2] && deep_pin) code = WC_GPIO;
      end
      PS_HIB: begin
        if (hib_tmr && match)       code = WC_TIMER;
        else if (|(gpio & hib_gpio)) code = WC_GPIO;
      end
      default: code = WC_NONE;
    endcase
  end

  assign hit = (code != WC_NONE);
endmodule

// File: rtl/pwr_pad_hold.sv
`timescale 1ns/1ps
module pwr_pad_hold #(
  parameter int NUM_GROUPS = 4,
  parameter int BOOT_GROUP = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enter_hib,
  input  logic                  hib_wake,
  input  logic                  in_hib,
  input  logic [NUM_GROUPS-1:0] keep,
  input  logic [NUM_GROUPS-1:0] rel,
  output logic [NUM_GROUPS-1:0] hold
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst)             hold[g] <= 1'b0;
      else if (enter_hib)  hold[g] <= hold[g] | keep[g];
      else if (in_hib) begin
        if (hib_wake && g == BOOT_GROUP) hold[g] <= 1'b0;
      end else if (rel[g]) hold[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl import pwr_pkg::*; #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_IRQ    = 8,
  parameter int NUM_GPIO   = 8,
  parameter int CNT_W      = 16,
  parameter int SLOW_DIV   = 4,
  parameter int LAT_SLEEP  = 2,
  parameter int LAT_DEEP   = 6,
  parameter int LAT_HIB    = 12,
  parameter logic [NUM_GPIO-1:0] DEEP_GPIO_OK = {NUM_GPIO{1'b1}} >> (NUM_GPIO / 2),
  localparam int SEL_W = (NUM_GPIO > 1) ? $clog2(NUM_GPIO) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [1:0]            req_mode,
  input  logic [CNT_W-1:0]      timer_cmp,
  input  logic [NUM_BANKS-1:0]  bank_keep,
  input  logic [NUM_IRQ-1:0]    sleep_irq_en,
  input  logic [2:0]            deep_src_en,
  input  logic [SEL_W-1:0]      deep_gpio_sel,
  input  logic                  hib_timer_en,
  input  logic [NUM_GPIO-1:0]   hib_gpio_en,
  input  logic [NUM_GROUPS-1:0] pad_grp_keep,
  input  logic [NUM_GROUPS-1:0] pad_release,
  input  logic [NUM_IRQ-1:0]    irq,
  input  logic                  np_irq,
  input  logic [NUM_GPIO-1:0]   gpio_wake,
  input  logic                  cause_rd,
  output logic                  cpu_clk_en,
  output logic                  periph_clk_en,
  output logic                  main_pwr_en,
  output logic [NUM_BANKS-1:0]  bank_ret_en,
  output logic [NUM_GROUPS-1:0] pad_hold,
  output logic [2:0]            wake_cause,
  output logic                  wake_ready,
  output logic [CNT_W-1:0]      slow_cnt
);
  localparam int LAT_MAX = (LAT_HIB > LAT_DEEP) ? ((LAT_HIB > LAT_SLEEP) ? LAT_HIB : LAT_SLEEP)
                                                : ((LAT_DEEP > LAT_SLEEP) ? LAT_DEEP : LAT_SLEEP);
  localparam int LAT_W = $clog2(LAT_MAX + 1);

  pstate_t               state;
  logic [LAT_W-1:0]      lat_cnt, lat_load;
  logic [NUM_IRQ-1:0]    sleep_en_q;
  logic [2:0]            deep_en_q;
  logic [SEL_W-1:0]      sel_q;
  logic                  hib_tmr_q;
  logic [NUM_GPIO-1:0]   hib_gpio_q;
  logic [CNT_W-1:0]      cmp_q;
  logic [NUM_BANKS-1:0]  keep_q;
  logic                  accept, hit, low_power;
  logic [2:0]            code;

  assign accept    = req_valid && (state == PS_ACTIVE) && (req_mode != REQ_ACTIVE);
  assign low_power = (state == PS_SLEEP) || (state == PS_DEEP) || (state == PS_HIB);

  pwr_slow_timer #(.CNT_W(CNT_W), .SLOW_DIV(SLOW_DIV)) u_slow (
    .clk(clk), .rst(rst), .count(slow_cnt)
  );

  pwr_wake_sel #(
    .NUM_IRQ(NUM_IRQ), .NUM_GPIO(NUM_GPIO), .CNT_W(CNT_W),
    .SEL_W(SEL_W), .DEEP_GPIO_OK(DEEP_GPIO_OK)
  ) u_wake (
    .state(state), .sleep_en(sleep_en_q), .deep_en(deep_en_q), .deep_sel(sel_q),
    .hib_tmr(hib_tmr_q), .hib_gpio(hib_gpio_q), .cmp(cmp_q), .slow(slow_cnt),
    .irq(irq), .np_irq(np_irq), .gpio(gpio_wake), .hit(hit), .code(code)
  );

  pwr_pad_hold #(.NUM_GROUPS(NUM_GROUPS), .BOOT_GROUP(1)) u_pad (
    .clk(clk), .rst(rst),
    .enter_hib(accept && (req_mode == REQ_HIB)),
    .hib_wake(hit), .in_hib(state == PS_HIB),
    .keep(pad_grp_keep), .rel(pad_release), .hold(pad_hold)
  );

  always_comb begin
    case (state)
      PS_SLEEP: lat_load = LAT_W'(LAT_SLEEP - 1);
      PS_DEEP:  lat_load = LAT_W'(LAT_DEEP - 1);
      default:  lat_load = LAT_W'(LAT_HIB - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PS_ACTIVE;
      lat_cnt    <= '0;
      wake_ready <= 1'b0;
      sleep_en_q <= '0;
      deep_en_q  <= '0;
      sel_q      <= '0;
      hib_tmr_q  <= 1'b0;
      hib_gpio_q <= '0;
      cmp_q      <= '0;
      keep_q     <= '0;
    end else begin
      wake_ready <= 1'b0;
      case (state)
        PS_ACTIVE: if (accept) begin
          state      <= pstate_t'({1'b0, req_mode});
          sleep_en_q <= sleep_irq_en;
          deep_en_q  <= deep_src_en;
          sel_q      <= deep_gpio_sel;
          hib_tmr_q  <= hib_timer_en;
          hib_gpio_q <= hib_gpio_en;
          cmp_q      <= timer_cmp;
          keep_q     <= bank_keep;
        end
        PS_WAKE: begin
          if (lat_cnt == '0) begin
            state      <= PS_ACTIVE;
            wake_ready <= 1'b1;
          end else begin
            lat_cnt <= lat_cnt - 1'b1;
          end
        end
        default: if (hit) begin
          state   <= PS_WAKE;
          lat_cnt <= lat_load;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    wake_cause <= WC_NONE;
    else if (low_power && hit)  wake_cause <= code;
    else if (cause_rd)          wake_cause <= WC_NONE;
  end

  always_comb begin
    cpu_clk_en    = (state == PS_ACTIVE);
    periph_clk_en = (state == PS_ACTIVE) || (state == PS_SLEEP) || (state == PS_WAKE);
    main_pwr_en   = (state != PS_HIB);
    case (state)
      PS_DEEP: bank_ret_en = keep_q;
      PS_HIB:  bank_ret_en = '0;
      default: bank_ret_en = '1;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(
  parameter int NUM_BANKS  = 4,
  parameter int NUM_GROUPS = 4,
  parameter int CNT_W      = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  cause_rd,
  input logic                  cpu_clk_en,
  input logic                  periph_clk_en,
  input logic                  main_pwr_en,
  input logic [NUM_BANKS-1:0]  bank_ret_en,
  input logic [NUM_GROUPS-1:0] pad_hold,
  input logic [2:0]            wake_cause,
  input logic                  wake_ready,
  input logic [CNT_W-1:0]      slow_cnt
);
  AST_PERIPH_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
    periph_clk_en |-> main_pwr_en); // R4
  AST_SLEEP_BANKS_ON: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && periph_clk_en) |-> (&bank_ret_en)); // R2
  AST_HIB_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    !main_pwr_en |-> ((bank_ret_en == '0) && !periph_clk_en && !cpu_clk_en)); // R6
  AST_SLOW_STEP: assert property (@(posedge clk) disable iff (rst)
    (slow_cnt == $past(slow_cnt)) || (slow_cnt == CNT_W'($past(slow_cnt) + 1'b1))); // R7
  AST_PAD_SET_IN_HIB: assert property (@(posedge clk) disable iff (rst)
    (|(pad_hold & ~$past(pad_hold))) |-> !main_pwr_en); // R8
  AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (cause_rd && cpu_clk_en) |=> (wake_cause == 3'd0)); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    wake_ready |-> (cpu_clk_en && $past(!cpu_clk_en))); // R10
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .NUM_GROUPS(NUM_GROUPS), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst(rst), .cause_rd(cause_rd), .cpu_clk_en(cpu_clk_en),
  .periph_clk_en(periph_clk_en), .main_pwr_en(main_pwr_en), .bank_ret_en(bank_ret_en),
  .pad_hold(pad_hold), .wake_cause(wake_cause), .wake_ready(wake_ready), .slow_cnt(slow_cnt)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int NB = 4, NG = 4, NI = 8, NP = 8, CW = 8, DIV = 3;
  localparam int LS = 2, LD = 5, LH = 9;
  localparam logic [NP-1:0] DEEP_OK = 8'h0F;

  logic clk = 0, rst = 1;
  logic req_valid = 0;
  logic [1:0] req_mode = 0;
  logic [CW-1:0] timer_cmp = 0;
  logic [NB-1:0] bank_keep = 0;
  logic [NI-1:0] sleep_irq_en = 0;
  logic [2:0] deep_src_en = 0;
  logic [2:0] deep_gpio_sel = 0;
  logic hib_timer_en = 0;
  logic [NP-1:0] hib_gpio_en = 0;
  logic [NG-1:0] pad_grp_keep = 0, pad_release = 0;
  logic [NI-1:0] irq = 0;
  logic np_irq = 0;
  logic [NP-1:0] gpio_wake = 0;
  logic cause_rd = 0;
  logic cpu_clk_en, periph_clk_en, main_pwr_en, wake_ready;
  logic [NB-1:0] bank_ret_en;
  logic [NG-1:0] pad_hold;
  logic [2:0] wake_cause;
  logic [CW-1:0] slow_cnt;

  pwr_mode_ctrl #(
    .NUM_BANKS(NB), .NUM_GROUPS(NG), .NUM_IRQ(NI), .NUM_GPIO(NP), .CNT_W(CW),
    .SLOW_DIV(DIV), .LAT_SLEEP(LS), .LAT_DEEP(LD), .LAT_HIB(LH), .DEEP_GPIO_OK(DEEP_OK)
  ) i_pwr_mode_ctrl (.*);

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit started = 0, done = 0;
  string phase = "R1";

  // reference model state: 0 run, 1 sleep, 2 deep, 3 hibernate, 4 waking
  int ms, mrem, mpre, mslow, mcause, mready;
  logic [NG-1:0] mpad;
  logic [NI-1:0] c_sl; logic [2:0] c_de; int c_sel; bit c_ht;
  logic [NP-1:0] c_hg; int c_cmp; logic [NB-1:0] c_bank;

  always @(posedge clk) begin
    int code;
    bit acc;
    started = 1;
    cycles++;
    if (rst) begin
      ms = 0; mrem = 0; mpre = 0; mslow = 0; mcause = 0; mready = 0; mpad = 0;
      c_sl = 0; c_de = 0; c_sel = 0; c_ht = 0; c_hg = 0; c_cmp = 0; c_bank = 0;
    end else begin
      code = 0;
      if (ms == 1) begin
        if ((irq & c_sl) != 0) code = 1;
      end else if (ms == 2) begin
        if (c_de[0] && np_irq) code = 2;
        else if (c_de[1] && mslow == c_cmp) code = 3;
        else if (c_de[2] && DEEP_OK[c_sel] && gpio_wake[c_sel]) code = 4;
      end else if (ms == 3) begin
        if (c_ht && mslow == c_cmp) code = 3;
        else if ((gpio_wake & c_hg) != 0) code = 4;
      end
      acc = (ms == 0) && req_valid && (req_mode != 0);
      if (acc && req_mode == 3) mpad = mpad | pad_grp_keep;
      else if (ms == 3) begin if (code != 0) mpad[1] = 1'b0; end
      else mpad = mpad & ~pad_release;
      if (ms >= 1 && ms <= 3 && code != 0) mcause = code;
      else if (cause_rd) mcause = 0;
      mready = 0;
      if (ms == 0) begin
        if (acc) begin
          ms = req_mode; c_sl = sleep_irq_en; c_de = deep_src_en; c_sel = deep_gpio_sel;
          c_ht = hib_timer_en; c_hg = hib_gpio_en; c_cmp = timer_cmp; c_bank = bank_keep;
        end
      end else if (ms == 4) begin
        if (mrem == 0) begin ms = 0; mready = 1; end else mrem--;
      end else if (code != 0) begin
        mrem = (ms == 1 ? LS : ms == 2 ? LD : LH) - 1;
        ms = 4;
      end
      if (mpre == DIV - 1) begin mpre = 0; mslow = (mslow + 1) % (1 << CW); end
      else mpre++;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(phase, "cpu_clk_en", cpu_clk_en, ms == 0);
      chk(phase, "periph_clk_en", periph_clk_en, ms == 0 || ms == 1 || ms == 4);
      chk(phase, "main_pwr_en", main_pwr_en, ms != 3);
      chk(phase, "bank_ret_en", bank_ret_en, ms == 2 ? c_bank : ms == 3 ? 0 : 4'hF);
      chk("R7", "slow_cnt", slow_cnt, mslow);
      chk("R8", "pad_hold", pad_hold, mpad);
      chk("R9", "wake_cause", wake_cause, mcause);
      chk("R10", "wake_ready", wake_ready, mready);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int mode);
    req_mode = 2'(mode); req_valid = 1; step(); req_valid = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    step(4); rst = 0; phase = "R1"; step(3);
    // R2, R3: light sleep with lines 0..3 enabled
    sleep_irq_en = 8'h0F; phase = "R2"; send(1); step(3);
    phase = "R3"; irq = 8'h20; step(2); irq = 0; step(2);
    phase = "R11"; send(2); step(2);
    phase = "R3"; irq = 8'h04; step(); irq = 0;
    phase = "R10"; step(LS + 3);
    cause_rd = 1; step(); cause_rd = 0; step(2);
    // R4, R5: deep sleep, network source only
    deep_src_en = 3'b001; bank_keep = 4'b0101; phase = "R4"; send(2); step(3);
    phase = "R5"; gpio_wake = 8'hFF; irq = 8'hFF; step(2); gpio_wake = 0; irq = 0; step();
    np_irq = 1; step(); np_irq = 0;
    phase = "R11"; send(3); step(LD + 4);
    // R5: deep sleep, timer match
    deep_src_en = 3'b010; bank_keep = 4'b1000; timer_cmp = CW'(mslow + 4);
    phase = "R5"; send(2); step(20);
    // R5: pin outside permitted set is ignored, then a permitted pin
    deep_src_en = 3'b101; deep_gpio_sel = 3'd5; send(2); step(2);
    gpio_wake = 8'h20; step(3); gpio_wake = 0; np_irq = 1; step(); np_irq = 0; step(LD + 3);
    deep_src_en = 3'b100; deep_gpio_sel = 3'd3; send(2); step(2);
    gpio_wake = 8'h08; step(); gpio_wake = 0; step(LD + 3);
    cause_rd = 1; step(); cause_rd = 0;
    // R6, R8: hibernate with pad groups 0, 1, 3 held
    pad_grp_keep = 4'b1011; hib_gpio_en = 8'h80; hib_timer_en = 0;
    phase = "R6"; send(3); step(3);
    phase = "R8"; pad_release = 4'hF; step(2); pad_release = 0;
    gpio_wake = 8'h40; step(2); gpio_wake = 8'h80; step(); gpio_wake = 0;
    step(LH + 3);
    pad_release = 4'b0001; step(); pad_release = 0; step(2);
    pad_release = 4'b1000; step(); pad_release = 0; step(2);
    // R6: hibernate timer wake
    pad_grp_keep = 4'b0100; hib_timer_en = 1; hib_gpio_en = 0; timer_cmp = CW'(mslow + 5);
    phase = "R6"; send(3); step(30);
    pad_release = 4'b0100; step(); pad_release = 0;
    // R7: let the slow counter wrap
    phase = "R7"; step(800);
    finish_run();
  end

  initial begin
    step(20000);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule